// File: doc/BRIEF.md
# Split-Operand Sequential Multiplier

This block multiplies two W-bit operands and returns the complete 2W-bit product without ever using a multiplier wider than half an operand. Each operand is cut into an upper and a lower half of W/2 bits. One half-by-half product is formed per clock cycle. The product is moved to its bit weight and added into a double-width accumulator. After four such steps, the full product is presented together with a one-cycle completion pulse.

The result keeps its full upper half. This matters to fixed-point callers: once the fraction bits are shifted out of a double-width product, the integer part lives in the upper half. A per-operation mode input selects between unsigned and two's complement operands. In signed mode the block multiplies the operand magnitudes and negates the sum when the operand signs differ. The most negative operand value is therefore handled without overflow.

To use the block, present the operands and mode with a one-cycle start while the block is idle. Then wait for the done pulse. A new operation may be started in the same cycle that done is high.

Top module: `split_mul`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are 0 and product is 0.
- R2: A start seen at a rising edge while busy is 0 captures opA, opB and signedMode, and busy is 1 after that edge.
- R3: If start is accepted at edge k, busy is 1 from edge k+1 through edge k+4. done is 1 only between edge k+4 and edge k+5.
- R4: With signedMode = 0, the product shown with done equals opA*opB as unsigned numbers, with all 2W bits kept.
- R5: The product is built from the four half products A0*B0, A1*B0, A0*B1 and A1*B1, which carry weights 1, 2^(W/2), 2^(W/2) and 2^W. For W = 4, operands 11 and 14 give 154.
- R6: With signedMode = 1, operands and product are two's complement. The 2W-bit product equals the signed product, including when either or both operands are the most negative value.
- R7: A start raised while busy is 1 is ignored. The running operation finishes at its original time with its original result.
- R8: product keeps its value between done pulses, whatever the inputs do.
- R9: A start in the cycle where done is 1 is accepted. The new operation then follows R3 from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product holds a new result |
| product | output | 2W | Full double-width result |

## Verification
Two functions can fall in the same cycle: the completion of one operation, with done high and product updated, and the acceptance of the next start. The bench provokes this by raising start, with fresh operands, in exactly the cycle it observes done. It then judges that busy rises on the next edge and that the second result arrives four edges later, correct against its own operands. The bench also overlaps a start with a running operation. It confirms that this start neither moves the done pulse nor changes the result.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;

  // Number of half-by-half products per operation.
  localparam int NUM_PARTS = 4;
  localparam int PART_IDX_W = $clog2(NUM_PARTS);

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  load;  // capture operands, clear accumulator
    logic                  step;  // add one shifted half product
    logic [PART_IDX_W-1:0] idx;   // bit0 picks A half, bit1 picks B half
    logic                  last;  // final step: publish the product
  } mulStrobe_t;

endpackage

// File: rtl/split_mul_ctrl.sv
module split_mul_ctrl
  import split_mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic {S_IDLE, S_RUN} ctrlState_t;

  localparam logic [PART_IDX_W-1:0] LAST_IDX = PART_IDX_W'(NUM_PARTS - 1);

  ctrlState_t            state;
  logic [PART_IDX_W-1:0] stepCnt;

  always_comb begin
    strobe.load = start && (state == S_IDLE);
    strobe.step = (state == S_RUN);
    strobe.idx  = stepCnt;
    strobe.last = (state == S_RUN) && (stepCnt == LAST_IDX);
  end

  assign busy = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.last;
      unique case (state)
        S_IDLE: begin
          if (strobe.load) begin
            state   <= S_RUN;
            stepCnt <= '0;
          end
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (strobe.last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: an accepted start makes the block busy on the next cycle
  a_r2_load_busy: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> busy);

  // R3: the final step is followed by exactly one done cycle
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    strobe.last |=> (done && !busy));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a running operation is not cut short by further starts
  a_r7_run_continues: assert property (@(posedge clk) disable iff (rst)
    (busy && !strobe.last) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

endmodule

// File: rtl/split_mul_dp.sv
module split_mul_dp
  import split_mul_pkg::*;
#(
  parameter int W              = 8,
  parameter bit SIGNED_SUPPORT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  mulStrobe_t     strobe,
  input  logic           signedMode,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [2*W-1:0] product
);

  localparam int H = W / 2;
  localparam int P = 2 * W;

  logic [W-1:0] magA, magB;
  logic         negIn;

  // Magnitudes; the most negative value maps to 2^(W-1) as unsigned.
  generate
    if (SIGNED_SUPPORT) begin : g_signed
      assign magA  = (signedMode && opA[W-1]) ? (~opA + 1'b1) : opA;
      assign magB  = (signedMode && opB[W-1]) ? (~opB + 1'b1) : opB;
      assign negIn = signedMode && (opA[W-1] ^ opB[W-1]);
    end else begin : g_unsigned
      assign magA  = opA;
      assign magB  = opB;
      assign negIn = 1'b0;
    end
  endgenerate

  logic [W-1:0] aReg, bReg;
  logic         negReg;
  logic [P-1:0] acc;

  logic [H-1:0] aHalf, bHalf;
  logic [W-1:0] partProd;
  logic [P-1:0] partExt, partShifted, accNext;
  logic [1:0]   weightSel;

  always_comb begin
    aHalf       = strobe.idx[0] ? aReg[W-1:H] : aReg[H-1:0];
    bHalf       = strobe.idx[1] ? bReg[W-1:H] : bReg[H-1:0];
    partProd    = {{(W-H){1'b0}}, aHalf} * {{(W-H){1'b0}}, bHalf};
    partExt     = {{W{1'b0}}, partProd};
    weightSel   = {1'b0, strobe.idx[0]} + {1'b0, strobe.idx[1]};
    unique case (weightSel)
      2'd0:    partShifted = partExt;
      2'd1:    partShifted = partExt << H;
      default: partShifted = partExt << W;
    endcase
    accNext     = acc + partShifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg    <= '0;
      bReg    <= '0;
      negReg  <= 1'b0;
      acc     <= '0;
      product <= '0;
    end else begin
      if (strobe.load) begin
        aReg   <= magA;
        bReg   <= magB;
        negReg <= negIn;
        acc    <= '0;
      end else if (strobe.step) begin
        acc <= accNext;
      end
      if (strobe.last) product <= negReg ? (~accNext + P'(1)) : accNext;
    end
  end

  // R8: product changes only when an operation completes
  a_r8_product_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.last |=> $stable(product));

  // R6: a nonzero result with unlike signs is negative
  a_r6_sign_of_result: assert property (@(posedge clk) disable iff (rst)
    (strobe.last && negReg && accNext != '0) |=> product[P-1]);

  // R5: the first step adds the low-by-low term to a cleared accumulator
  a_r5_first_term: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && strobe.idx == '0) |-> (acc == '0));

endmodule

// File: rtl/split_mul.sv
module split_mul
  import split_mul_pkg::*;
#(
  parameter int W              = 8,
  parameter bit SIGNED_SUPPORT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           signedMode,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  mulStrobe_t strobe;

  split_mul_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  split_mul_dp #(
    .W              (W),
    .SIGNED_SUPPORT (SIGNED_SUPPORT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .product    (product)
  );

  // R1: idle and cleared right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && product == '0));

endmodule

// File: tb/split_mul_bench.sv
`timescale 1ns/1ps
module split_mul_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sm = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] a8 = '0, b8 = '0;
  logic busy4, done4, busy8, done8;
  logic [7:0]  prod4;
  logic [15:0] prod8;

  int checks = 0;
  int errs = 0;

  always #4 clk = ~clk;

  split_mul #(.W(4), .SIGNED_SUPPORT(1'b1)) u_split_mul (
    .clk(clk), .rst(rst), .start(start), .signedMode(sm),
    .opA(a4), .opB(b4), .busy(busy4), .done(done4), .product(prod4));

  split_mul #(.W(8), .SIGNED_SUPPORT(1'b1)) u_split_mul_w8 (
    .clk(clk), .rst(rst), .start(start), .signedMode(sm),
    .opA(a8), .opB(b8), .busy(busy8), .done(done8), .product(prod8));

  function automatic logic [7:0] ref4(logic [3:0] x, logic [3:0] y, logic s);
    int ex = s ? int'($signed(x)) : int'(x);
    int ey = s ? int'($signed(y)) : int'(y);
    return 8'(ex * ey);
  endfunction

  function automatic logic [15:0] ref8(logic [7:0] x, logic [7:0] y, logic s);
    int ex = s ? int'($signed(x)) : int'(x);
    int ey = s ? int'($signed(y)) : int'(y);
    return 16'(ex * ey);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // Checks one result of each instance in the done cycle.
  task automatic chkResult(input logic [3:0] x4, input logic [3:0] y4,
                           input logic [7:0] x8, input logic [7:0] y8,
                           input logic s, input string req);
    logic [7:0]  e4 = ref4(x4, y4, s);
    logic [15:0] e8 = ref8(x8, y8, s);
    chk(done4 && done8, {"R3 done ", req}, {done4, done8}, 3);
    chk(prod4 == e4, {req, " w4"}, prod4, e4);
    chk(prod8 == e8, {req, " w8"}, prod8, e8);
  endtask

  // Full operation; returns at the negedge inside the done cycle.
  task automatic doOp(input logic [3:0] x4, input logic [3:0] y4,
                      input logic [7:0] x8, input logic [7:0] y8,
                      input logic s, input string req);
    @(negedge clk);
    a4 = x4; b4 = y4; a8 = x8; b8 = y8; sm = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy4 && busy8, "R2 busy after start", {busy4, busy8}, 3);
    repeat (3) @(negedge clk);
    chk(!done4 && !done8 && busy4, "R3 no early done", {done4, done8}, 0);
    @(negedge clk);
    chkResult(x4, y4, x8, y8, s, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy4 && !done4 && prod4 == 0 && prod8 == 0, "R1 during reset", prod4, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy4 && !done4 && !busy8 && !done8 && prod4 == 0 && prod8 == 0,
        "R1 after reset", {busy4, done4, busy8, done8}, 0);

    // R5 worked example
    doOp(4'd11, 4'd14, 8'd11, 8'd14, 1'b0, "R5 example");
    chk(prod4 == 8'd154, "R5 11x14", prod4, 154);

    // R4 and R6: exhaustive sweep of the narrow instance
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          doOp(4'(i), 4'(j), 8'($urandom), 8'($urandom), 1'(m),
               (m == 1) ? "R6 signed sweep" : "R4 unsigned sweep");
        end
      end
    end

    // R6 and R4 corners on the wide instance: zero, all ones, extremes
    begin
      logic [7:0] corner[4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
      logic [3:0] c4[4] = '{4'h0, 4'hF, 4'h8, 4'h7};
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            doOp(c4[i], c4[j], corner[i], corner[j], 1'(m),
                 (m == 1) ? "R6 corner" : "R4 corner");
    end

    // R7: start while busy is ignored
    @(negedge clk);
    a4 = 4'd9; b4 = 4'd13; a8 = 8'h80; b8 = 8'h80; sm = 1'b1; start = 1'b1;
    @(negedge clk);
    a4 = 4'd1; b4 = 4'd1; a8 = 8'd1; b8 = 8'd1; sm = 1'b0; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!done4, "R7 no early done", done4, 0);
    @(negedge clk);
    chk(!done4 && busy4, "R7 still running", busy4, 1);
    @(negedge clk);
    chkResult(4'd9, 4'd13, 8'h80, 8'h80, 1'b1, "R7 result kept");

    // R8: product holds while inputs move
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      a4 = 4'(k); a8 = 8'(k * 37); sm = ~sm;
      chk(prod4 == ref4(4'd9, 4'd13, 1'b1) && !done4, "R8 hold w4", prod4, ref4(4'd9, 4'd13, 1'b1));
      chk(prod8 == 16'h4000, "R8 hold w8", prod8, 16'h4000);
    end

    // R9: start in the done cycle
    doOp(4'd6, 4'd7, 8'd200, 8'd3, 1'b0, "R4 before back-to-back");
    a4 = 4'hC; b4 = 4'h5; a8 = 8'h81; b8 = 8'h7F; sm = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy4 && busy8 && !done4, "R9 accepted in done cycle", busy4, 1);
    repeat (3) @(negedge clk);
    chk(!done4, "R9 no early done", done4, 0);
    @(negedge clk);
    chkResult(4'hC, 4'h5, 8'h81, 8'h7F, 1'b1, "R9 second result");

    // R4 and R6: random operands on both instances
    for (int n = 0; n < 300; n++) begin
      doOp(4'($urandom), 4'($urandom), 8'($urandom), 8'($urandom), 1'(n % 2),
           (n % 2) ? "R6 random" : "R4 random");
    end

    summary();
    $finish;
  end

endmodule